// File: doc/BRIEF.md
# Asynchronous DRAM Cycle Decoder

This block models the device side of a one-bit-wide asynchronous DRAM interface. A fast clock samples the active-low row strobe, column strobe and write enable, together with the multiplexed address and the data input. The block works out what kind of cycle the controller is running from the order in which those strobes change. It keeps a small bit array, `2**(ROW_W+COL_W)` cells, and a refresh row counter. It drives the data output together with an output-enable that stands for the tri-state control.

The classes it recognises are:
- read
- early write
- read-modify-write
- fast-page read and fast-page write
- row-only refresh
- column-before-row refresh
- hidden refresh

Each class is reported as a code on `cycleKind`. A one-cycle `protoErr` pulse flags a column strobe that falls too soon after the row strobe. The block is meant as a synthesizable target or checker for a memory sequencer that runs at reduced depth.

Top module: `async_dram_decoder`

## Requirements
- R1: After reset, `doutOe` is 0, `cycleKind` is 0, `refRow` is 0 and `protoErr` is 0.
- R2: A fall of `casN` while `rasN` is low, with `weN` high, is a read. Two clock edges later, `doutOe` is 1, `dout` holds the cell at {row latched at the `rasN` fall, column on `addr`}, and `cycleKind` is 1.
- R3: If `weN` is low when `casN` falls, the cycle is an early write. `din` is stored in the addressed cell, `doutOe` stays 0, and `cycleKind` is 2.
- R4: A fall of `weN` while `casN` is still low in a read is a read-modify-write. `cycleKind` becomes 3, `dout` keeps the old cell value with `doutOe` at 1, and `din` is written to the cell.
- R5: A rise of `casN` makes `doutOe` 0. This holds in every cycle type.
- R6: If `rasN` falls with `casN` high and rises again with no `casN` fall, the cycle is a row-only refresh. `cycleKind` becomes 4, `doutOe` stays 0 and `refRow` does not change.
- R7: If `casN` is already low when `rasN` falls, the cycle is a column-before-row refresh and `cycleKind` becomes 5. `addr`, `weN` and `din` have no effect on the array. `refRow` steps by one when `rasN` rises.
- R8: If `rasN` rises and falls again while `casN` stays low after a read, the cycle is a hidden refresh. `dout` and `doutOe` keep the read value throughout, `cycleKind` becomes 6, and `refRow` steps by one when `rasN` rises again.
- R9: With `rasN` held low, each further fall of `casN` latches a new column in the same row. The access is reported as a fast-page read (`cycleKind` 7, with data on `dout`) or a fast-page write (`cycleKind` 8, with `doutOe` 0).
- R10: `protoErr` pulses for one cycle if `casN` falls fewer than `HOLD_CYC` samples after `rasN` fell. It stays 0 when the gap is at least `HOLD_CYC`.
- R11: `refRow` is `REF_W` bits wide and wraps from its maximum value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | max(ROW_W,COL_W) | Multiplexed row/column address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, 0 when not enabled |
| doutOe | output | 1 | Output enable (tri-state control) |
| cycleKind | output | 4 | Code of the last classified cycle |
| refRow | output | REF_W | Internal refresh row counter |
| protoErr | output | 1 | Row-hold violation pulse |

## Verification
Every result appears two rising clock edges after the pin change that causes it. One edge is the pin sampling register and the other is the control or datapath register. The bench therefore changes pins on a falling edge and reads the outputs two falling edges later. `protoErr` is a single-cycle pulse, so it is read in exactly that window, and the deliberate violation puts the column fall one sample after the row fall. Refresh counts are tracked in the bench and compared after each rise of the row strobe, including the wrap past the last row.

// File: rtl/adec_pkg.sv
package adec_pkg;

  typedef enum logic [3:0] {
    K_NONE    = 4'd0,
    K_READ    = 4'd1,
    K_EWRITE  = 4'd2,
    K_RMW     = 4'd3,
    K_RASONLY = 4'd4,
    K_CBR     = 4'd5,
    K_HIDDEN  = 4'd6,
    K_PAGERD  = 4'd7,
    K_PAGEWR  = 4'd8
  } cycKind_e;

  typedef enum logic [2:0] {
    S_IDLE,   // row strobe high, nothing open
    S_ROW,    // row open, no column yet
    S_ACC,    // column strobe low, access running
    S_PAGE,   // row open, column strobe back high
    S_CBR,    // refresh from internal counter
    S_HWAIT,  // row strobe high, column held low, data held
    S_HREF    // hidden refresh, row strobe low again
  } ctlState_e;

  typedef struct packed {
    logic latchRow;
    logic latchCol;
    logic rdOut;
    logic clrOut;
    logic wrBit;
    logic refStep;
  } strobe_t;

endpackage

// File: rtl/adec_sampler.sv
module adec_sampler #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              rasS,
  output logic              casS,
  output logic              weS,
  output logic [ADDR_W-1:0] addrS,
  output logic              dinS,
  output logic              rasFall,
  output logic              rasRise,
  output logic              casFall,
  output logic              casRise,
  output logic              weFall
);
  logic rasP, casP, weP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasS  <= 1'b1;
      casS  <= 1'b1;
      weS   <= 1'b1;
      rasP  <= 1'b1;
      casP  <= 1'b1;
      weP   <= 1'b1;
      addrS <= '0;
      dinS  <= 1'b0;
    end else begin
      rasP  <= rasS;
      casP  <= casS;
      weP   <= weS;
      rasS  <= rasN;
      casS  <= casN;
      weS   <= weN;
      addrS <= addr;
      dinS  <= din;
    end
  end

  assign rasFall = rasP & ~rasS;
  assign rasRise = ~rasP & rasS;
  assign casFall = casP & ~casS;
  assign casRise = ~casP & casS;
  assign weFall  = weP & ~weS;
endmodule

// File: rtl/adec_ctrl.sv
module adec_ctrl
  import adec_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     rasS,
  input  logic     casS,
  input  logic     weS,
  input  logic     rasFall,
  input  logic     rasRise,
  input  logic     casFall,
  input  logic     casRise,
  input  logic     weFall,
  output strobe_t  stb,
  output cycKind_e kind,
  output logic     protoErr
);
  localparam int AGE_W = $clog2(HOLD_CYC + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(HOLD_CYC);

  ctlState_e state, nState;
  cycKind_e  nKind;
  logic      accRead, nAccRead;
  logic [AGE_W-1:0] age;
  logic      errNext;

  always_comb begin
    stb      = '0;
    nState   = state;
    nKind    = kind;
    nAccRead = accRead;
    case (state)
      S_IDLE: begin
        if (rasFall) begin
          if (!casS) begin
            nState = S_CBR;
            nKind  = K_CBR;
          end else begin
            nState       = S_ROW;
            stb.latchRow = 1'b1;
          end
        end
      end
      S_ROW: begin
        if (rasRise) begin
          nState = S_IDLE;
          nKind  = K_RASONLY;
        end else if (casFall) begin
          nState       = S_ACC;
          stb.latchCol = 1'b1;
          if (weS) begin
            stb.rdOut = 1'b1;
            nKind     = K_READ;
            nAccRead  = 1'b1;
          end else begin
            stb.wrBit = 1'b1;
            nKind     = K_EWRITE;
            nAccRead  = 1'b0;
          end
        end
      end
      S_ACC: begin
        if (rasRise) begin
          if (casS) begin
            nState     = S_IDLE;
            stb.clrOut = 1'b1;
          end else begin
            nState = S_HWAIT;
          end
        end else if (casRise) begin
          nState     = S_PAGE;
          stb.clrOut = 1'b1;
        end else if (weFall && accRead) begin
          stb.wrBit = 1'b1;
          nKind     = K_RMW;
          nAccRead  = 1'b0;
        end
      end
      S_PAGE: begin
        if (rasRise) begin
          nState = S_IDLE;
        end else if (casFall) begin
          nState       = S_ACC;
          stb.latchCol = 1'b1;
          if (weS) begin
            stb.rdOut = 1'b1;
            nKind     = K_PAGERD;
            nAccRead  = 1'b1;
          end else begin
            stb.wrBit = 1'b1;
            nKind     = K_PAGEWR;
            nAccRead  = 1'b0;
          end
        end
      end
      S_CBR: begin
        if (rasRise) begin
          nState      = S_IDLE;
          stb.refStep = 1'b1;
        end
      end
      S_HWAIT: begin
        if (casRise) begin
          nState     = S_IDLE;
          stb.clrOut = 1'b1;
        end else if (rasFall) begin
          nState = S_HREF;
          nKind  = K_HIDDEN;
        end
      end
      S_HREF: begin
        if (rasRise) begin
          stb.refStep = 1'b1;
          if (casS) begin
            nState     = S_IDLE;
            stb.clrOut = 1'b1;
          end else begin
            nState = S_HWAIT;
          end
        end else if (casRise) begin
          nState     = S_CBR;
          stb.clrOut = 1'b1;
        end
      end
      default: nState = S_IDLE;
    endcase
  end

  assign errNext = (state == S_ROW) && casFall && !rasRise && (age < AGE_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      kind     <= K_NONE;
      accRead  <= 1'b0;
      age      <= '0;
      protoErr <= 1'b0;
    end else begin
      state    <= nState;
      kind     <= nKind;
      accRead  <= nAccRead;
      protoErr <= errNext;
      if (rasFall)
        age <= AGE_W'(1);
      else if (!rasS && age != AGE_MAX)
        age <= age + 1'b1;
    end
  end
endmodule

// File: rtl/adec_dpath.sv
module adec_dpath
  import adec_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int REF_W  = 9,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addrS,
  input  logic              dinS,
  output logic              dout,
  output logic              doutOe,
  output logic [REF_W-1:0]  refRow
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ, colSel;
  logic [IDX_W-1:0] idx;
  logic             cellQ [DEPTH];
  logic             doutQ;

  assign colSel = stb.latchCol ? addrS[COL_W-1:0] : colQ;
  assign idx    = {rowQ, colSel};

  always_ff @(posedge clk) begin
    if (stb.wrBit) cellQ[idx] <= dinS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ   <= '0;
      colQ   <= '0;
      doutQ  <= 1'b0;
      doutOe <= 1'b0;
      refRow <= '0;
    end else begin
      if (stb.latchRow) rowQ <= addrS[ROW_W-1:0];
      if (stb.latchCol) colQ <= addrS[COL_W-1:0];
      if (stb.rdOut) begin
        doutQ  <= cellQ[idx];
        doutOe <= 1'b1;
      end else if (stb.clrOut) begin
        doutOe <= 1'b0;
      end
      if (stb.refStep) refRow <= refRow + 1'b1;
    end
  end

  assign dout = doutQ & doutOe;
endmodule

// File: rtl/async_dram_decoder.sv
module async_dram_decoder
  import adec_pkg::*;
#(
  parameter int ROW_W    = 4,
  parameter int COL_W    = 4,
  parameter int REF_W    = 9,
  parameter int HOLD_CYC = 2
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         rasN,
  input  logic                                         casN,
  input  logic                                         weN,
  input  logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr,
  input  logic                                         din,
  output logic                                         dout,
  output logic                                         doutOe,
  output logic [3:0]                                   cycleKind,
  output logic [REF_W-1:0]                             refRow,
  output logic                                         protoErr
);
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic rasS, casS, weS, dinS;
  logic rasFall, rasRise, casFall, casRise, weFall;
  logic [ADDR_W-1:0] addrS;
  strobe_t  stb;
  cycKind_e kind;

  adec_sampler #(.ADDR_W(ADDR_W)) uSamp (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .din(din), .rasS(rasS), .casS(casS), .weS(weS),
    .addrS(addrS), .dinS(dinS), .rasFall(rasFall), .rasRise(rasRise),
    .casFall(casFall), .casRise(casRise), .weFall(weFall)
  );

  adec_ctrl #(.HOLD_CYC(HOLD_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .rasS(rasS), .casS(casS), .weS(weS),
    .rasFall(rasFall), .rasRise(rasRise), .casFall(casFall),
    .casRise(casRise), .weFall(weFall), .stb(stb), .kind(kind),
    .protoErr(protoErr)
  );

  adec_dpath #(.ROW_W(ROW_W), .COL_W(COL_W), .REF_W(REF_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .addrS(addrS), .dinS(dinS),
    .dout(dout), .doutOe(doutOe), .refRow(refRow)
  );

  assign cycleKind = kind;
endmodule

// File: rtl/adec_chk.sv
module adec_chk #(
  parameter int REF_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             casFall,
  input logic             casRise,
  input logic             rasRise,
  input logic             weFall,
  input logic             doutOe,
  input logic [3:0]       cycleKind,
  input logic [REF_W-1:0] refRow,
  input logic             protoErr
);
  // R5
  cas_release_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    casRise |=> !doutOe);

  // R2
  drive_only_reads_chk: assert property (@(posedge clk) disable iff (!rstN)
    doutOe |-> (cycleKind == 4'd1 || cycleKind == 4'd3 ||
                cycleKind == 4'd6 || cycleKind == 4'd7));

  // R3
  early_write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleKind == 4'd2 && $past(cycleKind) != 4'd2) |-> !doutOe);

  // R4
  rmw_from_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleKind == 4'd3 && $past(cycleKind) != 4'd3) |-> ($past(weFall) && doutOe));

  // R10
  hold_err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $past(casFall));

  // R11
  ref_step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refRow != $past(refRow)) |-> (refRow == REF_W'($past(refRow) + 1'b1)));

  // R7
  ref_on_ras_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refRow != $past(refRow)) |-> $past(rasRise));
endmodule

bind async_dram_decoder adec_chk #(.REF_W(REF_W)) uChk (
  .clk(clk), .rstN(rstN), .casFall(casFall), .casRise(casRise),
  .rasRise(rasRise), .weFall(weFall), .doutOe(doutOe),
  .cycleKind(cycleKind), .refRow(refRow), .protoErr(protoErr)
);

// File: tb/async_dram_decoder_test.sv
module async_dram_decoder_test;
  localparam int ROW_W = 4;
  localparam int COL_W = 4;
  localparam int REF_W = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1, din = 1'b0;
  logic [3:0] addr = '0;
  logic dout, doutOe, protoErr;
  logic [3:0] cycleKind;
  logic [REF_W-1:0] refRow;

  int nChecks = 0;
  int nFails = 0;
  int expRef = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  async_dram_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .REF_W(REF_W), .HOLD_CYC(2)) uut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .din(din), .dout(dout), .doutOe(doutOe),
    .cycleKind(cycleKind), .refRow(refRow), .protoErr(protoErr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic doWrite(input int row, input int col, input logic b);
    @(negedge clk); addr = 4'(row); rasN = 1'b0;
    settle();
    addr = 4'(col); din = b; weN = 1'b0; casN = 1'b0;
    settle();
    chk("R3 kind", cycleKind, 2);
    chk("R3 oe", doutOe, 0);
    chk("R10 no err", protoErr, 0);
    casN = 1'b1; weN = 1'b1;
    settle();
    rasN = 1'b1;
    settle();
  endtask

  task automatic doRead(input int row, input int col, input int exp);
    @(negedge clk); addr = 4'(row); rasN = 1'b0;
    settle();
    addr = 4'(col); casN = 1'b0;
    settle();
    chk("R2 kind", cycleKind, 1);
    chk("R2 oe", doutOe, 1);
    chk("R2 data", dout, exp);
    casN = 1'b1;
    settle();
    chk("R5 oe off", doutOe, 0);
    rasN = 1'b1;
    settle();
  endtask

  task automatic doRmw();
    @(negedge clk); addr = 4'd3; rasN = 1'b0;
    settle();
    addr = 4'd6; casN = 1'b0;
    settle();
    chk("R4 old read", dout, 0);
    weN = 1'b0; din = 1'b1;
    settle();
    chk("R4 kind", cycleKind, 3);
    chk("R4 oe", doutOe, 1);
    chk("R4 old kept", dout, 0);
    casN = 1'b1; weN = 1'b1;
    settle();
    rasN = 1'b1;
    settle();
    doRead(3, 6, 1);
  endtask

  task automatic doRasOnly();
    @(negedge clk); addr = 4'd9; rasN = 1'b0;
    settle();
    rasN = 1'b1;
    settle();
    chk("R6 kind", cycleKind, 4);
    chk("R6 oe", doutOe, 0);
    chk("R6 ref", refRow, expRef);
    doRead(9, 2, 1);
  endtask

  task automatic doCbr();
    @(negedge clk); casN = 1'b0;
    settle();
    addr = 4'd3; weN = 1'b0; din = 1'b0; rasN = 1'b0;
    settle();
    chk("R7 kind", cycleKind, 5);
    chk("R7 oe", doutOe, 0);
    rasN = 1'b1;
    settle();
    expRef++;
    chk("R7 ref step", refRow, expRef);
    casN = 1'b1; weN = 1'b1;
    settle();
    doRead(3, 5, 1);
  endtask

  task automatic doHidden();
    @(negedge clk); addr = 4'd9; rasN = 1'b0;
    settle();
    addr = 4'd2; casN = 1'b0;
    settle();
    chk("R8 read", dout, 1);
    rasN = 1'b1;
    settle();
    chk("R8 oe held", doutOe, 1);
    chk("R8 data held", dout, 1);
    rasN = 1'b0;
    settle();
    chk("R8 kind", cycleKind, 6);
    chk("R8 data in refresh", dout, 1);
    rasN = 1'b1;
    settle();
    expRef++;
    chk("R8 ref step", refRow, expRef);
    casN = 1'b1;
    settle();
    chk("R5 hidden oe off", doutOe, 0);
  endtask

  task automatic doPage();
    @(negedge clk); addr = 4'd3; rasN = 1'b0;
    settle();
    addr = 4'd5; casN = 1'b0;
    settle();
    chk("R9 first read", dout, 1);
    casN = 1'b1;
    settle();
    addr = 4'd7; weN = 1'b0; din = 1'b1; casN = 1'b0;
    settle();
    chk("R9 page write kind", cycleKind, 8);
    chk("R9 page write oe", doutOe, 0);
    casN = 1'b1; weN = 1'b1;
    settle();
    addr = 4'd6; casN = 1'b0;
    settle();
    chk("R9 page read kind", cycleKind, 7);
    chk("R9 page read data", dout, 1);
    casN = 1'b1;
    settle();
    addr = 4'd7; casN = 1'b0;
    settle();
    chk("R9 page readback", dout, 1);
    casN = 1'b1;
    settle();
    rasN = 1'b1;
    settle();
  endtask

  task automatic doHoldErr();
    @(negedge clk); addr = 4'd9; rasN = 1'b0;
    @(negedge clk); addr = 4'd5; casN = 1'b0;
    settle();
    chk("R10 err pulse", protoErr, 1);
    chk("R10 access kept", dout, 0);
    @(negedge clk);
    chk("R10 pulse ends", protoErr, 0);
    casN = 1'b1;
    settle();
    rasN = 1'b1;
    settle();
  endtask

  task automatic quickCbr();
    @(negedge clk); casN = 1'b0;
    @(negedge clk); rasN = 1'b0;
    repeat (2) @(negedge clk);
    rasN = 1'b1;
    @(negedge clk); casN = 1'b1;
    @(negedge clk);
    expRef = (expRef + 1) % 512;
  endtask

  task automatic doWrap();
    while (expRef != 511) quickCbr();
    settle();
    chk("R11 at max", refRow, 511);
    quickCbr();
    settle();
    chk("R11 wrapped", refRow, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    chk("R1 oe", doutOe, 0);
    chk("R1 kind", cycleKind, 0);
    chk("R1 ref", refRow, 0);
    chk("R1 err", protoErr, 0);
    doWrite(3, 5, 1'b1);
    doWrite(3, 6, 1'b0);
    doWrite(9, 5, 1'b0);
    doWrite(9, 2, 1'b1);
    doRead(3, 5, 1);
    doRead(3, 6, 0);
    doRead(9, 5, 0);
    doRead(9, 2, 1);
    doRmw();
    doRasOnly();
    doCbr();
    doHidden();
    doPage();
    doRead(3, 7, 1);
    doHoldErr();
    doWrap();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule